// File: doc/BRIEF.md
# Parity-Checked Three-Slot Cipher Key Bank

This block holds the three 56-bit keys that a block-cipher datapath needs. The master slot protects session keys in transit. The encipher slot is used to encrypt traffic, and the decipher slot is used to decrypt it. Each key leaves the block on its own output bus. No path exists through which key contents could be read back onto either byte port.

A load begins with a command that names the target slot and the port that will supply the bytes. That port is either the host byte port or the auxiliary byte port. Eight byte writes follow on the chosen port. Each byte must have odd parity over all eight bits, and bit 0 is the parity bit. The block drops the parity bit and shifts the upper seven bits into a shadow register, first byte most significant. The target slot is overwritten only when all eight bytes have passed, so a failed load leaves the old key in place.

The master slot accepts cleartext loading only from the auxiliary port. A reset aborts any load in progress and clears the status flags, but it keeps the stored keys.

Top module: `keybank`

## Requirements
- R1: After a synchronous reset, `cmd_pending`, `load_done` and `parity_err` are 0. Key values already stored are unchanged by the reset.
- R2: In a cycle with `cmd_valid`=1 and a permitted command, the next cycle shows `cmd_pending`=1, `load_done`=0 and `parity_err`=0. The target encodings are 1 = master, 2 = encipher and 3 = decipher. Target 0 is ignored and leaves `cmd_pending` at 0.
- R3: A master-key command with `cmd_aux`=0 (host port) is rejected. `cmd_pending` stays 0, and host bytes that follow do not change `master_key`.
- R4: A byte is taken only while `cmd_pending`=1, and only from the port the command selected (`cmd_aux`=1 for auxiliary, 0 for host). Bytes on the other port, and bytes sent while nothing is pending, have no effect on keys or flags.
- R5: A byte is good when its eight bits hold an odd number of ones. A bad byte sets `parity_err`, which holds until the next accepted command or reset. The same byte clears `cmd_pending` and leaves the target key unchanged.
- R6: Bits [7:1] of each accepted byte form seven key bits. The first byte lands in key bits [55:49] and the eighth in bits [6:0].
- R7: The edge that accepts the eighth good byte has three effects: the target key output takes the new value, `cmd_pending` drops to 0 and `load_done` rises to 1. The other two keys are unchanged.
- R8: A new permitted command issued while a load is pending restarts the byte count and discards the bytes already received.
- R9: A reset during a load discards the partial key. The target key keeps its earlier value, and later bytes are ignored until a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Load-key command strobe |
| cmd_target | input | 2 | Target slot: 0 none, 1 master, 2 encipher, 3 decipher |
| cmd_aux | input | 1 | Source port of the bytes: 1 auxiliary, 0 host |
| host_we | input | 1 | Host byte write strobe |
| host_byte | input | 8 | Host key byte |
| aux_we | input | 1 | Auxiliary byte write strobe |
| aux_byte | input | 8 | Auxiliary key byte |
| cmd_pending | output | 1 | A load is in progress and bytes are expected |
| load_done | output | 1 | The last load completed and was committed |
| parity_err | output | 1 | Sticky flag: a byte failed the odd-parity check |
| master_key | output | 56 | Stored master key |
| enc_key | output | 56 | Stored encipher key |
| dec_key | output | 56 | Stored decipher key |

## Verification
The hardest situations to reach from the ports are those where a byte must be refused although a load is in progress. Examples are a byte on the unselected port, or a bad byte arriving after several good ones. In both cases a wrong result would only show later, as a corrupted key. The bench places bad-parity bytes on the idle port in between good bytes, and checks that the committed key matches only the selected port's stream. It also aborts loads part-way, by a parity error, by a restart command and by a reset. After each abort it compares the target key against the value it held before the load began.

// File: rtl/keybank_pkg.sv
package keybank_pkg;

    localparam int unsigned BYTE_W_DEF    = 8;
    localparam int unsigned KEY_BYTES_DEF = 8;
    localparam int unsigned NUM_SLOTS     = 3;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_MASTER = 2'd1,
        TGT_ENC    = 2'd2,
        TGT_DEC    = 2'd3
    } key_tgt_e;

    typedef struct packed {
        key_tgt_e tgt;
        logic     aux;
    } load_cmd_t;

    // Odd parity over the whole byte, parity bit included.
    function automatic logic parity_good(input logic [BYTE_W_DEF-1:0] b);
        return ^b;
    endfunction

    // Master slot may only be filled from the auxiliary port.
    function automatic logic cmd_permitted(input load_cmd_t c);
        return (c.tgt != TGT_NONE) && ((c.tgt != TGT_MASTER) || c.aux);
    endfunction

endpackage

// File: rtl/kb_intake.sv
module kb_intake
    import keybank_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_W_DEF
) (
    input  logic              pending,
    input  logic              sel_aux,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              aux_we,
    input  logic [BYTE_W-1:0] aux_byte,
    output logic              byte_valid,
    output logic              byte_ok,
    output logic [BYTE_W-2:0] byte_bits
);

    logic [BYTE_W-1:0] chosen;

    always_comb begin
        chosen     = sel_aux ? aux_byte : host_byte;
        byte_valid = pending && (sel_aux ? aux_we : host_we);
        byte_ok    = ^chosen;
        byte_bits  = chosen[BYTE_W-1:1];
    end

endmodule

// File: rtl/kb_sequencer.sv
module kb_sequencer
    import keybank_pkg::*;
#(
    parameter int unsigned BYTE_W    = BYTE_W_DEF,
    parameter int unsigned KEY_BYTES = KEY_BYTES_DEF,
    localparam int unsigned BW       = BYTE_W - 1,
    localparam int unsigned KEY_W    = KEY_BYTES * BW,
    localparam int unsigned SH_W     = KEY_W - BW,
    localparam int unsigned CNT_W    = $clog2(KEY_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  load_cmd_t        cmd,
    input  logic             byte_valid,
    input  logic             byte_ok,
    input  logic [BW-1:0]    byte_bits,
    output logic             pending,
    output logic             sel_aux,
    output logic             done,
    output logic             perr,
    output logic             commit_valid,
    output key_tgt_e         commit_tgt,
    output logic [KEY_W-1:0] commit_value
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_BYTES - 1);

    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  shadow;
    key_tgt_e         tgt_q;
    logic             start;
    logic             last_byte;

    always_comb begin
        start        = cmd_valid && cmd_permitted(cmd);
        last_byte    = (cnt == LAST);
        commit_valid = !rst && !start && byte_valid && byte_ok && last_byte;
        commit_tgt   = tgt_q;
        commit_value = {shadow, byte_bits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            done    <= 1'b0;
            perr    <= 1'b0;
            cnt     <= '0;
            tgt_q   <= TGT_NONE;
            sel_aux <= 1'b0;
            shadow  <= '0;
        end else if (start) begin
            pending <= 1'b1;
            done    <= 1'b0;
            perr    <= 1'b0;
            cnt     <= '0;
            tgt_q   <= cmd.tgt;
            sel_aux <= cmd.aux;
            shadow  <= '0;
        end else if (byte_valid) begin
            if (!byte_ok) begin
                perr    <= 1'b1;
                pending <= 1'b0;
                cnt     <= '0;
            end else if (last_byte) begin
                pending <= 1'b0;
                done    <= 1'b1;
                cnt     <= '0;
            end else begin
                shadow  <= {shadow[SH_W-BW-1:0], byte_bits};
                cnt     <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/kb_key_store.sv
module kb_key_store
    import keybank_pkg::*;
#(
    parameter int unsigned KEY_W = KEY_BYTES_DEF * (BYTE_W_DEF - 1),
    parameter int unsigned SLOTS = NUM_SLOTS
) (
    input  logic             clk,
    input  logic             commit_valid,
    input  key_tgt_e         commit_tgt,
    input  logic [KEY_W-1:0] commit_value,
    output logic [KEY_W-1:0] key_q [SLOTS]
);

    // Key slots are deliberately not reset: stored keys survive a reset.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [1:0] SLOT_ID = 2'(g + 1);
        always_ff @(posedge clk) begin
            if (commit_valid && (commit_tgt == key_tgt_e'(SLOT_ID))) begin
                key_q[g] <= commit_value;
            end
        end
    end

endmodule

// File: rtl/keybank.sv
module keybank
    import keybank_pkg::*;
#(
    parameter int unsigned BYTE_W    = BYTE_W_DEF,
    parameter int unsigned KEY_BYTES = KEY_BYTES_DEF,
    localparam int unsigned KEY_W    = KEY_BYTES * (BYTE_W - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_target,
    input  logic              cmd_aux,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              aux_we,
    input  logic [BYTE_W-1:0] aux_byte,
    output logic              cmd_pending,
    output logic              load_done,
    output logic              parity_err,
    output logic [KEY_W-1:0]  master_key,
    output logic [KEY_W-1:0]  enc_key,
    output logic [KEY_W-1:0]  dec_key
);

    load_cmd_t         cmd;
    logic              sel_aux;
    logic              byte_valid;
    logic              byte_ok;
    logic [BYTE_W-2:0] byte_bits;
    logic              commit_valid;
    key_tgt_e          commit_tgt;
    logic [KEY_W-1:0]  commit_value;
    logic [KEY_W-1:0]  key_q [NUM_SLOTS];

    always_comb begin
        cmd.tgt = key_tgt_e'(cmd_target);
        cmd.aux = cmd_aux;
    end

    kb_intake #(.BYTE_W(BYTE_W)) u_intake (
        .pending    (cmd_pending),
        .sel_aux    (sel_aux),
        .host_we    (host_we),
        .host_byte  (host_byte),
        .aux_we     (aux_we),
        .aux_byte   (aux_byte),
        .byte_valid (byte_valid),
        .byte_ok    (byte_ok),
        .byte_bits  (byte_bits)
    );

    kb_sequencer #(.BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd          (cmd),
        .byte_valid   (byte_valid),
        .byte_ok      (byte_ok),
        .byte_bits    (byte_bits),
        .pending      (cmd_pending),
        .sel_aux      (sel_aux),
        .done         (load_done),
        .perr         (parity_err),
        .commit_valid (commit_valid),
        .commit_tgt   (commit_tgt),
        .commit_value (commit_value)
    );

    kb_key_store #(.KEY_W(KEY_W), .SLOTS(NUM_SLOTS)) u_store (
        .clk          (clk),
        .commit_valid (commit_valid),
        .commit_tgt   (commit_tgt),
        .commit_value (commit_value),
        .key_q        (key_q)
    );

    always_comb begin
        master_key = key_q[0];
        enc_key    = key_q[1];
        dec_key    = key_q[2];
    end

endmodule

// File: rtl/keybank_checker.sv
module keybank_checker #(
    parameter int unsigned KEY_W = 56
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [1:0]       cmd_target,
    input logic             cmd_aux,
    input logic             cmd_pending,
    input logic             load_done,
    input logic             parity_err,
    input logic [KEY_W-1:0] master_key,
    input logic [KEY_W-1:0] enc_key,
    input logic [KEY_W-1:0] dec_key
);

    // R1
    reset_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cmd_pending && !load_done && !parity_err));

    // R2
    pending_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_pending) |-> $past(cmd_valid));

    // R3
    master_host_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_target == 2'd1 && !cmd_aux && !cmd_pending) |=> !cmd_pending);

    // R5
    perr_ends_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(parity_err) |-> !cmd_pending);

    // R5
    done_err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(load_done && parity_err));

    // R7
    done_ends_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> !cmd_pending);

    // R7
    keys_change_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(load_done) |-> ($stable(master_key) && $stable(enc_key) && $stable(dec_key)));

endmodule

bind keybank keybank_checker #(.KEY_W(KEY_W)) u_keybank_checker (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_target  (cmd_target),
    .cmd_aux     (cmd_aux),
    .cmd_pending (cmd_pending),
    .load_done   (load_done),
    .parity_err  (parity_err),
    .master_key  (master_key),
    .enc_key     (enc_key),
    .dec_key     (dec_key)
);

// File: tb/keybank_bench.sv
`timescale 1ns/1ps
module keybank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_target = 2'd0;
    logic        cmd_aux = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_byte = 8'h00;
    logic        aux_we = 1'b0;
    logic [7:0]  aux_byte = 8'h00;
    logic        cmd_pending;
    logic        load_done;
    logic        parity_err;
    logic [55:0] master_key;
    logic [55:0] enc_key;
    logic [55:0] dec_key;

    int tests = 0;
    int fails = 0;
    logic [55:0] exp_m, exp_e, exp_d;

    always #2 clk = ~clk;

    keybank u_keybank (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_target(cmd_target),
        .cmd_aux(cmd_aux), .host_we(host_we), .host_byte(host_byte),
        .aux_we(aux_we), .aux_byte(aux_byte), .cmd_pending(cmd_pending),
        .load_done(load_done), .parity_err(parity_err), .master_key(master_key),
        .enc_key(enc_key), .dec_key(dec_key)
    );

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    function automatic logic [6:0] dval(input int seed, input int i);
        return 7'(seed * 13 + i * 29 + 5);
    endfunction

    function automatic logic [7:0] good_byte(input logic [6:0] d);
        return {d, ~(^d)};
    endfunction

    function automatic logic [7:0] bad_byte(input logic [6:0] d);
        return {d, ^d};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic send_cmd(input logic [1:0] tgt, input logic aux);
        cmd_valid = 1'b1; cmd_target = tgt; cmd_aux = aux;
        tick();
        cmd_valid = 1'b0; cmd_target = 2'd0; cmd_aux = 1'b0;
    endtask

    task automatic send_byte(input logic aux, input logic [7:0] b);
        if (aux) begin aux_we = 1'b1; aux_byte = b; end
        else begin host_we = 1'b1; host_byte = b; end
        tick();
        aux_we = 1'b0; host_we = 1'b0;
    endtask

    task automatic check_keys(input string tag);
        chk({tag, " master_key"}, 64'(master_key), 64'(exp_m));
        chk({tag, " enc_key"}, 64'(enc_key), 64'(exp_e));
        chk({tag, " dec_key"}, 64'(dec_key), 64'(exp_d));
    endtask

    // Full good load; updates expected key model. Used for R6/R7.
    task automatic load_key(input logic [1:0] tgt, input logic aux, input int seed);
        logic [55:0] k = '0;
        send_cmd(tgt, aux);
        chk("R2 pending after command", 64'(cmd_pending), 64'd1);
        for (int i = 0; i < 8; i++) begin
            send_byte(aux, good_byte(dval(seed, i)));
            k = {k[48:0], dval(seed, i)};
            if (i == 6) chk("R7 pending before last byte", 64'(cmd_pending), 64'd1);
        end
        case (tgt)
            2'd1: exp_m = k;
            2'd2: exp_e = k;
            default: exp_d = k;
        endcase
        chk("R7 pending cleared", 64'(cmd_pending), 64'd0);
        chk("R7 load_done set", 64'(load_done), 64'd1);
        chk("R5 no parity error", 64'(parity_err), 64'd0);
        check_keys("R6 R7 packed key");
    endtask

    task automatic t_reset_state();
        chk("R1 pending after reset", 64'(cmd_pending), 64'd0);
        chk("R1 done after reset", 64'(load_done), 64'd0);
        chk("R1 perr after reset", 64'(parity_err), 64'd0);
    endtask

    task automatic t_loads();
        load_key(2'd1, 1'b1, 1);
        load_key(2'd2, 1'b0, 2);
        load_key(2'd3, 1'b0, 3);
        load_key(2'd2, 1'b1, 4);
        chk("R6 first byte in top bits", 64'(enc_key[55:49]), 64'(dval(4, 0)));
        chk("R6 last byte in low bits", 64'(enc_key[6:0]), 64'(dval(4, 7)));
    endtask

    task automatic t_keys_kept_on_reset();
        do_reset();
        t_reset_state();
        check_keys("R1 keys kept over reset");
    endtask

    task automatic t_target_none();
        send_cmd(2'd0, 1'b0);
        chk("R2 target 0 ignored", 64'(cmd_pending), 64'd0);
    endtask

    task automatic t_master_host_reject();
        send_cmd(2'd1, 1'b0);
        chk("R3 master via host rejected", 64'(cmd_pending), 64'd0);
        for (int i = 0; i < 8; i++) send_byte(1'b0, good_byte(dval(9, i)));
        chk("R3 done stays", 64'(load_done), 64'd1);
        check_keys("R3 master unchanged");
    endtask

    task automatic t_wrong_port_ignored();
        logic [55:0] k = '0;
        send_byte(1'b0, bad_byte(7'h11));
        chk("R4 idle byte ignored", 64'(parity_err), 64'd0);
        send_cmd(2'd3, 1'b0);
        for (int i = 0; i < 8; i++) begin
            send_byte(1'b1, bad_byte(dval(20, i)));
            send_byte(1'b0, good_byte(dval(5, i)));
            k = {k[48:0], dval(5, i)};
        end
        exp_d = k;
        chk("R4 other port no error", 64'(parity_err), 64'd0);
        chk("R4 load completes", 64'(load_done), 64'd1);
        check_keys("R4 key from selected port");
    endtask

    task automatic t_parity_error();
        send_cmd(2'd3, 1'b1);
        for (int i = 0; i < 3; i++) send_byte(1'b1, good_byte(dval(6, i)));
        send_byte(1'b1, bad_byte(dval(6, 3)));
        chk("R5 perr set", 64'(parity_err), 64'd1);
        chk("R5 pending cleared", 64'(cmd_pending), 64'd0);
        chk("R5 done clear", 64'(load_done), 64'd0);
        for (int i = 4; i < 8; i++) send_byte(1'b1, good_byte(dval(6, i)));
        chk("R5 perr sticky", 64'(parity_err), 64'd1);
        check_keys("R5 key unchanged");
        send_cmd(2'd2, 1'b0);
        chk("R2 command clears perr", 64'(parity_err), 64'd0);
        send_cmd(2'd0, 1'b0);
    endtask

    task automatic t_restart();
        send_cmd(2'd2, 1'b0);
        for (int i = 0; i < 4; i++) send_byte(1'b0, good_byte(dval(30, i)));
        load_key(2'd2, 1'b0, 7);
        check_keys("R8 restart discards bytes");
    endtask

    task automatic t_reset_midload();
        send_cmd(2'd2, 1'b0);
        for (int i = 0; i < 5; i++) send_byte(1'b0, good_byte(dval(40, i)));
        do_reset();
        chk("R9 pending cleared", 64'(cmd_pending), 64'd0);
        for (int i = 5; i < 8; i++) send_byte(1'b0, good_byte(dval(40, i)));
        chk("R9 later bytes ignored", 64'(load_done), 64'd0);
        check_keys("R9 key unchanged");
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_loads();
        t_keys_kept_on_reset();
        load_key(2'd1, 1'b1, 8);
        t_target_none();
        t_master_host_reject();
        t_wrong_port_ignored();
        t_parity_error();
        t_restart();
        t_reset_midload();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule